// File: doc/BRIEF.md
# Rotate and Shift Unit with Flags

This block performs the eight classic rotate and shift operations on a byte or a word operand and returns the new value together with the arithmetic flags those operations produce. Four operations rotate (plainly, or through the incoming carry bit). Four operations shift (left, logical right, arithmetic right, and a second encoding of shift left). Each flag also comes with its own write-enable, so the flag register next to the block knows which bits the operation defines. Bits whose enable is low are left for the caller to keep.

The count is reduced by rules that depend on the operation and on the width. Plain rotates reduce it modulo the width, and a nonzero count that reduces to zero still writes carry and overflow. Rotates through carry reduce modulo the width plus one, and a zero remainder changes nothing. Arithmetic right shifts clamp the count at the width. Any shift with a zero count changes nothing.

The operation itself is combinational. It sits behind a single output register with a valid/ready handshake on both sides. A request is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output register holds every output steady and `in_ready` is low.

Top module: `shiftrot_unit`

## Requirements
- R1: Only bits 4:0 of `in_count` take part; bits 7:5 have no effect on any output.
- R2: `in_op` encodes 0 rotate left, 1 rotate right, 2 rotate left through carry, 3 rotate right through carry, 4 shift left, 5 logical shift right, 6 shift left (same behaviour as 4), 7 arithmetic shift right.
- R3: For ops 0 and 1 the rotate amount is the masked count modulo the width (8 when `in_wide`=0, 16 when 1). A masked count of zero leaves the result equal to the operand with no flag enabled. A nonzero masked count whose amount is zero leaves the result unchanged but still writes CF and OF.
- R4: After op 0, CF = result bit 0 and OF = result bit 0 XOR result MSB. After op 1, CF = result MSB and OF = XOR of the two top result bits. Ops 0 to 3 enable only CF and OF.
- R5: Ops 2 and 3 rotate the operand together with `in_cf` by the masked count modulo 9 (byte) or 17 (word); a zero remainder changes nothing. CF is the bit that lands in carry. OF is new CF XOR result MSB for op 2, and the XOR of the two top result bits for op 3.
- R6: For ops 4, 5 and 6 with a nonzero count, CF is the last bit shifted out, and both CF and the result are zero once the count exceeds the width.
- R7: For op 7 a count above the width acts as the width: every result bit equals the operand's sign and CF equals the sign.
- R8: A shift (ops 4 to 7) with a masked count of zero returns the operand and enables no flag.
- R9: A shift enables OF only when the masked count is 1. OF is then result MSB XOR CF for a left shift, the original MSB for op 5, and 0 for op 7.
- R10: A shift with a nonzero count enables SF, ZF and PF. SF is the result MSB, ZF is set when the result is zero, and PF is set when the low 8 result bits hold an even number of ones.
- R11: `out_flags` and `out_flag_we` use bit 0 CF, bit 1 PF, bit 2 ZF, bit 3 SF, bit 4 OF. Any flag bit whose enable is low reads 0, and in byte mode `out_result[15:8]` is 0 and `in_operand[15:8]` is ignored.
- R12: After reset `out_valid` is 0. An accepted request appears at the outputs on the next clock edge. `in_ready` = !`out_valid` || `out_ready`, and a stalled output holds stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_op | input | 3 | Operation code (R2) |
| in_wide | input | 1 | 0 byte operand, 1 word operand |
| in_operand | input | 16 | Value to rotate or shift |
| in_count | input | 8 | Raw count, low 5 bits used |
| in_cf | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Outputs hold a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 16 | Rotated or shifted value |
| out_flags | output | 5 | New flag values (R11 layout) |
| out_flag_we | output | 5 | Write-enable per flag (R11 layout) |

## Verification
The bench builds the block with its default widths: a 16-bit word lane, an 8-bit byte lane and an 8-bit raw count. With these widths every opcode, both widths, every masked count from 0 to 31 and both carry inputs can be swept against a model that steps one bit position at a time. That sweep reaches the modulo-9 and modulo-17 wrap points, the multiple-of-width rotates, and shifts far beyond the width. The high count bits are varied across the sweep, and one result is held under back-pressure to cover the handshake.

// File: rtl/shiftrot_pkg.sv
package shiftrot_pkg;

  typedef enum logic [2:0] {
    OP_ROTL     = 3'd0,
    OP_ROTR     = 3'd1,
    OP_RCARL    = 3'd2,
    OP_RCARR    = 3'd3,
    OP_SHL      = 3'd4,
    OP_SHR      = 3'd5,
    OP_SHL_ALT  = 3'd6,
    OP_SAR      = 3'd7
  } sr_op_e;

  localparam int FLAG_N = 5;
  localparam int FI_CF  = 0;
  localparam int FI_PF  = 1;
  localparam int FI_ZF  = 2;
  localparam int FI_SF  = 3;
  localparam int FI_OF  = 4;

endpackage

// File: rtl/shiftrot_count.sv
module shiftrot_count #(
  parameter int W      = 8,
  parameter int CNT_W  = 8,
  parameter int MASK_W = 5
) (
  input  logic [CNT_W-1:0]  raw,
  output logic [MASK_W-1:0] masked,
  output logic [MASK_W-1:0] rot_amt,
  output logic [MASK_W-1:0] rc_amt,
  output logic              is_one
);
  localparam int MASK_MOD = 1 << MASK_W;
  localparam logic [MASK_W-1:0] ROT_MOD = MASK_W'(W);
  localparam logic [MASK_W-1:0] RC_MOD  = MASK_W'(W + 1);

  always_comb begin
    masked  = MASK_W'(raw % CNT_W'(MASK_MOD));
    rot_amt = masked % ROT_MOD;
    rc_amt  = masked % RC_MOD;
    is_one  = (masked == MASK_W'(1));
  end
endmodule

// File: rtl/shiftrot_rotate.sv
module shiftrot_rotate #(
  parameter int W     = 8,
  parameter int AMT_W = 5
) (
  input  logic [W-1:0]     val,
  input  logic             cin,
  input  logic [AMT_W-1:0] rot_amt,
  input  logic [AMT_W-1:0] rc_amt,
  output logic [W-1:0]     rol_res,
  output logic [W-1:0]     ror_res,
  output logic [W-1:0]     rcl_res,
  output logic             rcl_cf,
  output logic [W-1:0]     rcr_res,
  output logic             rcr_cf
);
  logic [W:0] ext;
  logic [W:0] rcl_word;
  logic [W:0] rcr_word;

  always_comb begin
    // plain rotate: amount is already below W
    rol_res = (val << rot_amt) | (val >> (AMT_W'(W) - rot_amt));
    ror_res = (val >> rot_amt) | (val << (AMT_W'(W) - rot_amt));
    // through carry: the carry is the top bit of a W+1 ring
    ext      = {cin, val};
    rcl_word = (ext << rc_amt) | (ext >> (AMT_W'(W + 1) - rc_amt));
    rcr_word = (ext >> rc_amt) | (ext << (AMT_W'(W + 1) - rc_amt));
    rcl_res  = rcl_word[W-1:0];
    rcl_cf   = rcl_word[W];
    rcr_res  = rcr_word[W-1:0];
    rcr_cf   = rcr_word[W];
  end
endmodule

// File: rtl/shiftrot_shift.sv
module shiftrot_shift #(
  parameter int W     = 8,
  parameter int AMT_W = 5
) (
  input  logic [W-1:0]     val,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     shl_res,
  output logic             shl_cf,
  output logic [W-1:0]     shr_res,
  output logic             shr_cf,
  output logic [W-1:0]     sar_res,
  output logic             sar_cf
);
  logic [W:0]        left_t;
  logic [W:0]        right_t;
  logic [AMT_W-1:0]  sar_amt;
  logic signed [W:0] sar_t;

  always_comb begin
    // guard bit above (left) or below (right) catches the last bit out
    left_t  = {1'b0, val} << amt;
    right_t = {val, 1'b0} >> amt;
    sar_amt = (amt > AMT_W'(W)) ? AMT_W'(W) : amt;
    sar_t   = $signed({val, 1'b0}) >>> sar_amt;
    shl_res = left_t[W-1:0];
    shl_cf  = left_t[W];
    shr_res = right_t[W:1];
    shr_cf  = right_t[0];
    sar_res = sar_t[W:1];
    sar_cf  = sar_t[0];
  end
endmodule

// File: rtl/shiftrot_lane.sv
module shiftrot_lane
  import shiftrot_pkg::*;
#(
  parameter int W      = 8,
  parameter int CNT_W  = 8,
  parameter int MASK_W = 5
) (
  input  logic [2:0]        op,
  input  logic [W-1:0]      val,
  input  logic [CNT_W-1:0]  count,
  input  logic              cin,
  output logic [W-1:0]      res,
  output logic [FLAG_N-1:0] flags,
  output logic [FLAG_N-1:0] flag_we
);
  logic [MASK_W-1:0] masked, rot_amt, rc_amt;
  logic              is_one;
  logic [W-1:0]      rol_res, ror_res, rcl_res, rcr_res;
  logic              rcl_cf, rcr_cf;
  logic [W-1:0]      shl_res, shr_res, sar_res;
  logic              shl_cf, shr_cf, sar_cf;
  logic              szp_en;

  shiftrot_count #(.W(W), .CNT_W(CNT_W), .MASK_W(MASK_W)) u_count (
    .raw(count), .masked(masked), .rot_amt(rot_amt), .rc_amt(rc_amt), .is_one(is_one)
  );

  shiftrot_rotate #(.W(W), .AMT_W(MASK_W)) u_rotate (
    .val(val), .cin(cin), .rot_amt(rot_amt), .rc_amt(rc_amt),
    .rol_res(rol_res), .ror_res(ror_res),
    .rcl_res(rcl_res), .rcl_cf(rcl_cf),
    .rcr_res(rcr_res), .rcr_cf(rcr_cf)
  );

  shiftrot_shift #(.W(W), .AMT_W(MASK_W)) u_shift (
    .val(val), .amt(masked),
    .shl_res(shl_res), .shl_cf(shl_cf),
    .shr_res(shr_res), .shr_cf(shr_cf),
    .sar_res(sar_res), .sar_cf(sar_cf)
  );

  always_comb begin
    res     = val;
    flags   = '0;
    flag_we = '0;
    szp_en  = 1'b0;
    unique case (sr_op_e'(op))
      OP_ROTL: if (masked != '0) begin
        res            = rol_res;
        flag_we[FI_CF] = 1'b1;
        flag_we[FI_OF] = 1'b1;
        flags[FI_CF]   = rol_res[0];
        flags[FI_OF]   = rol_res[0] ^ rol_res[W-1];
      end
      OP_ROTR: if (masked != '0) begin
        res            = ror_res;
        flag_we[FI_CF] = 1'b1;
        flag_we[FI_OF] = 1'b1;
        flags[FI_CF]   = ror_res[W-1];
        flags[FI_OF]   = ror_res[W-1] ^ ror_res[W-2];
      end
      OP_RCARL: if (rc_amt != '0) begin
        res            = rcl_res;
        flag_we[FI_CF] = 1'b1;
        flag_we[FI_OF] = 1'b1;
        flags[FI_CF]   = rcl_cf;
        flags[FI_OF]   = rcl_cf ^ rcl_res[W-1];
      end
      OP_RCARR: if (rc_amt != '0) begin
        res            = rcr_res;
        flag_we[FI_CF] = 1'b1;
        flag_we[FI_OF] = 1'b1;
        flags[FI_CF]   = rcr_cf;
        flags[FI_OF]   = rcr_res[W-1] ^ rcr_res[W-2];
      end
      OP_SHL, OP_SHL_ALT: if (masked != '0) begin
        res            = shl_res;
        szp_en         = 1'b1;
        flag_we[FI_CF] = 1'b1;
        flags[FI_CF]   = shl_cf;
        flag_we[FI_OF] = is_one;
        flags[FI_OF]   = is_one & (shl_res[W-1] ^ shl_cf);
      end
      OP_SHR: if (masked != '0) begin
        res            = shr_res;
        szp_en         = 1'b1;
        flag_we[FI_CF] = 1'b1;
        flags[FI_CF]   = shr_cf;
        flag_we[FI_OF] = is_one;
        flags[FI_OF]   = is_one & val[W-1];
      end
      OP_SAR: if (masked != '0) begin
        res            = sar_res;
        szp_en         = 1'b1;
        flag_we[FI_CF] = 1'b1;
        flags[FI_CF]   = sar_cf;
        flag_we[FI_OF] = is_one;
        flags[FI_OF]   = 1'b0;
      end
      default: ;
    endcase
    if (szp_en) begin
      flag_we[FI_SF] = 1'b1;
      flag_we[FI_ZF] = 1'b1;
      flag_we[FI_PF] = 1'b1;
      flags[FI_SF]   = res[W-1];
      flags[FI_ZF]   = ~|res;
      flags[FI_PF]   = ~^res[7:0];
    end
  end
endmodule

// File: rtl/shiftrot_unit.sv
module shiftrot_unit
  import shiftrot_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic              in_wide,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [CNT_W-1:0]  in_count,
  input  logic              in_cf,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [FLAG_N-1:0] out_flags,
  output logic [FLAG_N-1:0] out_flag_we
);
  localparam int NARROW_W = DATA_W / 2;
  localparam int MASK_W   = 5;
  localparam int LANES    = 2;

  logic [DATA_W-1:0] lane_res [LANES];
  logic [FLAG_N-1:0] lane_fl  [LANES];
  logic [FLAG_N-1:0] lane_we  [LANES];
  logic              sel;
  logic              accept;

  // lane 0 works on the narrow operand, lane 1 on the full one
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : DATA_W;
    logic [LW-1:0] res_g;

    shiftrot_lane #(.W(LW), .CNT_W(CNT_W), .MASK_W(MASK_W)) u_lane (
      .op(in_op), .val(in_operand[LW-1:0]), .count(in_count), .cin(in_cf),
      .res(res_g), .flags(lane_fl[g]), .flag_we(lane_we[g])
    );

    assign lane_res[g] = DATA_W'(res_g);
  end

  assign sel      = in_wide;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_flags   <= '0;
      out_flag_we <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        out_result  <= lane_res[sel];
        out_flags   <= lane_fl[sel];
        out_flag_we <= lane_we[sel];
      end
    end
  end
endmodule

// File: rtl/shiftrot_checker.sv
module shiftrot_checker #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic              in_wide,
  input logic [DATA_W-1:0] in_operand,
  input logic [CNT_W-1:0]  in_count,
  input logic              in_cf,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic [4:0]        out_flags,
  input logic [4:0]        out_flag_we
);
  localparam int NARROW_W = DATA_W / 2;
  localparam int MASK_W   = 5;

  logic fire;
  assign fire = in_valid && in_ready;

  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                   $stable(out_flags) && $stable(out_flag_we)));

  p_ready_when_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_quiet_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_flags & ~out_flag_we) == '0));

  p_narrow_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_wide) |=> (out_result[DATA_W-1:NARROW_W] == '0));

  p_shift_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op[2] && in_wide && in_count[MASK_W-1:0] == '0)
      |=> (out_flag_we == '0 && out_result == $past(in_operand)));

  p_count_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_count[MASK_W-1:0] == '0 && in_count[CNT_W-1:MASK_W] != '0)
      |=> (out_flag_we == '0));

  p_rot_no_szp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_op[2]) |=> (out_flag_we[3:1] == 3'b000));

  p_shift_szp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op[2] && in_count[MASK_W-1:0] != '0) |=> (out_flag_we[3:1] == 3'b111));

  p_sar_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == 3'd7 && in_wide && in_count[MASK_W-1:0] >= MASK_W'(DATA_W))
      |=> (out_result == {DATA_W{$past(in_operand[DATA_W-1])}}));

  p_rcl_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == 3'd2 && in_count[MASK_W-1:0] == MASK_W'(1))
      |=> (out_result[0] == $past(in_cf)));
endmodule

bind shiftrot_unit shiftrot_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/shiftrot_unit_tb.sv
module shiftrot_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic        in_wide = 1'b0;
  logic [15:0] in_operand = '0;
  logic [7:0]  in_count = '0;
  logic        in_cf = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic [4:0]  out_flags;
  logic [4:0]  out_flag_we;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shiftrot_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wide(in_wide), .in_operand(in_operand), .in_count(in_count),
    .in_cf(in_cf), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags), .out_flag_we(out_flag_we)
  );

  // bit layout: 0 CF, 1 PF, 2 ZF, 3 SF, 4 OF
  function automatic void model(input logic [2:0] op, input logic wide,
                                input logic [15:0] opnd, input logic [7:0] cnt,
                                input logic cf_in, output logic [15:0] r,
                                output logic [4:0] fl, output logic [4:0] we);
    int w;
    int m;
    logic [15:0] mask, v, orig;
    logic c, nb, sign;
    w    = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    v    = opnd & mask;
    orig = v;
    m    = int'(cnt) % 32;
    fl   = '0;
    we   = '0;
    c    = cf_in;
    sign = v[w-1];
    case (op)
      3'd0: if (m != 0) begin
        for (int i = 0; i < m; i++) v = ((v << 1) | (v >> (w - 1))) & mask;
        we = 5'b10001; fl[0] = v[0]; fl[4] = v[0] ^ v[w-1];
      end
      3'd1: if (m != 0) begin
        for (int i = 0; i < m; i++) v = ((v >> 1) | (v << (w - 1))) & mask;
        we = 5'b10001; fl[0] = v[w-1]; fl[4] = v[w-1] ^ v[w-2];
      end
      3'd2: if (m % (w + 1) != 0) begin
        for (int i = 0; i < m; i++) begin
          nb = v[w-1]; v = ((v << 1) | {15'd0, c}) & mask; c = nb;
        end
        we = 5'b10001; fl[0] = c; fl[4] = c ^ v[w-1];
      end
      3'd3: if (m % (w + 1) != 0) begin
        for (int i = 0; i < m; i++) begin
          nb = v[0]; v = (v >> 1) | ({15'd0, c} << (w - 1)); c = nb;
        end
        we = 5'b10001; fl[0] = c; fl[4] = v[w-1] ^ v[w-2];
      end
      default: if (m != 0) begin
        for (int i = 0; i < m; i++) begin
          if (op == 3'd5) begin c = v[0]; v = v >> 1; end
          else if (op == 3'd7) begin c = v[0]; v = (v >> 1) | ({15'd0, sign} << (w - 1)); end
          else begin c = v[w-1]; v = (v << 1) & mask; end
        end
        we = 5'b01111; fl[0] = c;
        fl[3] = v[w-1]; fl[2] = (v == 16'd0); fl[1] = ~^v[7:0];
        if (m == 1) begin
          we[4] = 1'b1;
          if (op == 3'd5) fl[4] = orig[w-1];
          else if (op == 3'd7) fl[4] = 1'b0;
          else fl[4] = v[w-1] ^ c;
        end
      end
    endcase
    r = v;
  endfunction

  function automatic string tag_for(input logic [2:0] op, input logic [7:0] cnt,
                                    input int field);
    string t;
    if (field == 2) t = "R11";
    else if (op == 3'd0 || op == 3'd1) t = (field == 0) ? "R3" : "R4";
    else if (op == 3'd2 || op == 3'd3) t = "R5";
    else if (cnt[4:0] == 5'd0) t = "R8";
    else if (field == 1) t = "R9/R10";
    else if (op == 3'd7) t = "R7";
    else t = "R6";
    if (op == 3'd6) t = {t, "/R2"};
    if (cnt[7:5] != 3'd0) t = {t, "/R1"};
    return t;
  endfunction

  task automatic apply(input logic [2:0] op, input logic wide, input logic [15:0] opnd,
                       input logic [7:0] cnt, input logic cf);
    logic [15:0] er;
    logic [4:0]  ef, ew;
    bit bad;
    model(op, wide, opnd, cnt, cf, er, ef, ew);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_wide = wide; in_operand = opnd;
    in_count = cnt; in_cf = cf; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    vectors++;
    bad = 1'b0;
    if (!out_valid) begin
      bad = 1'b1;
      $display("FAIL R12 out_valid actual=%0b expected=1", out_valid);
    end
    if (out_result !== er) begin
      bad = 1'b1;
      $display("FAIL %s op=%0d wide=%0b opnd=%h cnt=%0d cf=%0b result actual=%h expected=%h",
               tag_for(op, cnt, (!wide && out_result[15:8] != 8'd0) ? 2 : 0),
               op, wide, opnd, cnt, cf, out_result, er);
    end
    if (out_flag_we !== ew || out_flags !== ef) begin
      bad = 1'b1;
      $display("FAIL %s op=%0d wide=%0b opnd=%h cnt=%0d cf=%0b flags/we actual=%b/%b expected=%b/%b",
               tag_for(op, cnt, ((out_flags & ~out_flag_we) != 5'd0) ? 2 : 1),
               op, wide, opnd, cnt, cf, out_flags, out_flag_we, ef, ew);
    end
    if (bad) miscompares++;
  endtask

  initial begin
    logic [15:0] pats [6];
    logic [15:0] er;
    logic [4:0]  ef, ew;
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h8001;
    pats[3] = 16'h5A3C; pats[4] = 16'h7FFE; pats[5] = 16'hA5C3;

    repeat (3) @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      miscompares++;
      $display("FAIL R12 reset out_valid/in_ready actual=%b%b expected=01", out_valid, in_ready);
    end
    rst_n = 1'b1;

    // exhaustive sweep: op x width x count x carry x operand pattern
    for (int op = 0; op < 8; op++)
      for (int wd = 0; wd < 2; wd++)
        for (int c = 0; c < 32; c++)
          for (int cf = 0; cf < 2; cf++)
            for (int p = 0; p < 6; p++)
              apply(3'(op), wd[0], pats[p], 8'(c + 32 * ((c + p + op) % 8)), cf[0]);

    // back-pressure hold (R12)
    model(3'd2, 1'b1, 16'h9C31, 8'd5, 1'b1, er, ef, ew);
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'd2; in_wide = 1'b1; in_operand = 16'h9C31;
    in_count = 8'd5; in_cf = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      vectors++;
      if (!out_valid || in_ready || out_result !== er || out_flags !== ef || out_flag_we !== ew) begin
        miscompares++;
        $display("FAIL R12 stall v/r/res actual=%b%b/%h expected=10/%h",
                 out_valid, in_ready, out_result, er);
      end
    end
    out_ready = 1'b1;
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R12 drain out_valid actual=%b expected=0", out_valid);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule